// File: doc/BRIEF.md
# Serial Control Bus Register Slave

This block lets a host controller configure and poll a tone signalling unit over a five-wire serial link. The host lowers the active-low chip select, clocks bytes in on a command line and clocks bytes back on a separate reply line. Every access opens with an address byte. That byte picks either a write-only configuration register or a read-only register. Data bytes for a write-only register are gathered and committed when the last byte completes. A read-only register is snapshotted and shifted out on the reply line.

The block also gathers three single-cycle event pulses from neighbouring units: general timer expiry, no-tone timer expiry and tone measurement done. Each pulse sets a sticky flag in the status register. The control register gates these flags onto an interrupt output. That output only ever pulls low, so several slaves can share one pulled-up request line. In this design the output is modelled as a drive-enable signal.

All serial pins are brought into the system clock domain through two-flop synchronisers. The serial clock is then edge-detected in that domain.

Top module: `sbus_slave`

## Requirements
- R1: Bits are taken on the rising serial clock edge, most significant bit first. A two-byte write to address 33h (no-tone period), 34h (tone 1), 35h (tone 2) or 36h (general timer) loads the first data byte into the upper half of the register and the second into the lower half. The register changes only when the final byte completes.
- R2: A one-byte write to address 30h loads the 8-bit control register.
- R3: Raising chip select part-way through a byte drops that byte, leaves every register unchanged and returns the block to waiting for an address byte.
- R4: `reply_en` is low unless a reply byte is being shifted out. Reply bits change after the falling serial clock edge and are valid at the next rising edge.
- R5: Reading address 31h returns one byte. Bit 0 is the general timer flag, bit 1 the no-tone flag, bit 2 the measurement-done flag and bit 3 the synchronised logic input. Bits 7:4 read as zero.
- R6: Reading address 32h returns the 16-bit measured frequency as two bytes, upper byte first, snapshotted when the reply starts.
- R7: An event pulse sets its status flag and the flag stays set. A complete status read clears only the flags that read returned, at the end of the status byte. An event that arrives during the read survives.
- R8: `irq_drive` is high exactly when control bit 7 is 1 and at least one pending flag is unmasked. Control bit 5 masks the general timer flag. Control bit 6 masks the no-tone and measurement flags.
- R9: An address byte that matches no register is ignored. Following bytes are dropped until chip select rises, no register changes and no reply is driven.
- R10: Bytes after the last data byte of a write are dropped, and the register keeps the committed value.
- R11: After reset, every configuration register and flag is zero and `reply_en` and `irq_drive` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Serial clock from the host |
| csn_in | input | 1 | Active-low chip select |
| cmd_in | input | 1 | Command data from the host |
| logic_in | input | 1 | General purpose logic level reported in status |
| ev_gpt | input | 1 | General timer expiry pulse |
| ev_notone | input | 1 | No-tone timer expiry pulse |
| ev_meas | input | 1 | Tone measurement done pulse |
| rx_freq | input | 8*FBYTES | Measured receive frequency word |
| reply_d | output | 1 | Reply data bit |
| reply_en | output | 1 | Reply drive enable; low means high impedance |
| irq_drive | output | 1 | 1 pulls the shared request line low |
| ctrl_q | output | 8 | Control register |
| notone_q | output | 8*WBYTES | No-tone period register |
| tone1_q | output | 8*WBYTES | Tone 1 frequency register |
| tone2_q | output | 8*WBYTES | Tone 2 frequency register |
| gpt_q | output | 8*WBYTES | General timer period register |

## Verification
The registered path is two synchroniser flops, an edge detector, a byte strobe and the commit. A configuration register therefore takes its new value about five system cycles after the last rising serial edge. A reply bit settles about four cycles after a falling edge, and `irq_drive` follows an event pulse or a control write within two cycles. Each serial half period lasts eight system clocks, and the bench samples reply bits on its own rising serial edge, long after they settle. Register and interrupt checks run only after the chip select release wait, so each result is read well after it is due. Expected reply bytes go into a scoreboard queue before each read and are compared as they arrive.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam logic [7:0] A_CTRL   = 8'h30;
  localparam logic [7:0] A_STAT   = 8'h31;
  localparam logic [7:0] A_FREQ   = 8'h32;
  localparam logic [7:0] A_NOTONE = 8'h33;
  localparam logic [7:0] A_TONE1  = 8'h34;
  localparam logic [7:0] A_TONE2  = 8'h35;
  localparam logic [7:0] A_GPT    = 8'h36;

  typedef enum logic [1:0] {PH_ADDR, PH_WRITE, PH_READ, PH_DROP} phase_t;
endpackage

// File: rtl/sbus_sync.sv
module sbus_sync #(
  parameter int         W      = 1,
  parameter int         STAGES = 2,
  parameter logic [W-1:0] RSTV = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RSTV;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sbus_framer.sv
module sbus_framer #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cs_act,
  input  logic            sclk_s,
  input  logic            din_s,
  output logic            sclk_rise,
  output logic            sclk_fall,
  output logic            byte_valid,
  output logic [BITS-1:0] byte_data
);
  localparam int CW = $clog2(BITS);

  logic          sclk_d;
  logic [CW-1:0] cnt;
  logic [BITS-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  assign sclk_rise = cs_act &  sclk_s & ~sclk_d;
  assign sclk_fall = cs_act & ~sclk_s &  sclk_d;

  // partial byte is dropped whenever chip select is inactive
  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      cnt        <= '0;
      sh         <= '0;
      byte_valid <= 1'b0;
      if (rst) byte_data <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (sclk_rise) begin
        sh <= {sh[BITS-2:0], din_s};
        if (cnt == CW'(BITS-1)) begin
          cnt        <= '0;
          byte_valid <= 1'b1;
          byte_data  <= {sh[BITS-2:0], din_s};
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sbus_irq.sv
module sbus_irq #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] ev,
  input  logic            clr,
  input  logic [NSRC-1:0] clr_mask,
  input  logic            en_all,
  input  logic [NSRC-1:0] src_dis,
  output logic [NSRC-1:0] flags,
  output logic            irq_drive
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags     <= '0;
      irq_drive <= 1'b0;
    end else begin
      flags     <= (flags & ~(clr ? clr_mask : '0)) | ev;
      irq_drive <= en_all & |(flags & ~src_dis);
    end
  end
endmodule

// File: rtl/sbus_slave.sv
module sbus_slave import sbus_pkg::*; #(
  parameter int WBYTES = 2,
  parameter int FBYTES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sclk_in,
  input  logic                  csn_in,
  input  logic                  cmd_in,
  input  logic                  logic_in,
  input  logic                  ev_gpt,
  input  logic                  ev_notone,
  input  logic                  ev_meas,
  input  logic [8*FBYTES-1:0]   rx_freq,
  output logic                  reply_d,
  output logic                  reply_en,
  output logic                  irq_drive,
  output logic [7:0]            ctrl_q,
  output logic [8*WBYTES-1:0]   notone_q,
  output logic [8*WBYTES-1:0]   tone1_q,
  output logic [8*WBYTES-1:0]   tone2_q,
  output logic [8*WBYTES-1:0]   gpt_q
);
  localparam int DW  = 8 * WBYTES;
  localparam int FW  = 8 * FBYTES;
  localparam int RW  = (FW > 8) ? FW : 8;
  localparam int BCW = $clog2(RW + 1);
  localparam int IW  = $clog2(WBYTES + 1);

  logic sclk_s, csn_s, cmd_s, logic_s, cs_act;
  sbus_sync #(.W(4), .STAGES(2), .RSTV(4'b0100)) u_sync (
    .clk(clk), .rst(rst),
    .d({logic_in, csn_in, sclk_in, cmd_in}),
    .q({logic_s, csn_s, sclk_s, cmd_s})
  );
  assign cs_act = ~csn_s;

  logic       sclk_rise, sclk_fall, byte_valid;
  logic [7:0] byte_data;
  sbus_framer #(.BITS(8)) u_frm (
    .clk(clk), .rst(rst), .cs_act(cs_act), .sclk_s(sclk_s), .din_s(cmd_s),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .byte_valid(byte_valid), .byte_data(byte_data)
  );

  phase_t          phase;
  logic [7:0]      addr;
  logic [IW-1:0]   idx;
  logic [DW-1:0]   wacc;
  logic            load_pend, stat_pend, clr_pulse;
  logic [2:0]      clr_mask, flags;
  logic [RW-1:0]   rsh, ld_val;
  logic [BCW-1:0]  rbits, ld_cnt;
  logic [DW+7:0]   cat;
  logic [DW-1:0]   wr_val;
  logic            last_w, wr_fire, addr_wr, addr_rd;
  logic [7:0]      stat_byte;

  assign cat       = {wacc, byte_data};
  assign wr_val    = cat[DW-1:0];
  assign last_w    = (addr == A_CTRL) ? (idx == '0) : (idx == IW'(WBYTES - 1));
  assign wr_fire   = cs_act && byte_valid && (phase == PH_WRITE) && last_w;
  assign addr_wr   = (byte_data == A_CTRL) || (byte_data == A_NOTONE) ||
                     (byte_data == A_TONE1) || (byte_data == A_TONE2) ||
                     (byte_data == A_GPT);
  assign addr_rd   = (byte_data == A_STAT) || (byte_data == A_FREQ);
  assign stat_byte = {4'b0000, logic_s, flags};

  always_comb begin
    ld_val = '0;
    if (addr == A_STAT) begin
      ld_val[RW-1 -: 8] = stat_byte;
      ld_cnt            = BCW'(7);
    end else begin
      ld_val[RW-1 -: FW] = rx_freq;
      ld_cnt             = BCW'(FW - 1);
    end
  end

  // transaction sequencing and reply shifting
  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      phase     <= PH_ADDR;
      addr      <= '0;
      idx       <= '0;
      wacc      <= '0;
      load_pend <= 1'b0;
      stat_pend <= 1'b0;
      clr_pulse <= 1'b0;
      clr_mask  <= '0;
      rsh       <= '0;
      rbits     <= '0;
      reply_d   <= 1'b0;
      reply_en  <= 1'b0;
    end else begin
      clr_pulse <= 1'b0;
      if (byte_valid) begin
        unique case (phase)
          PH_ADDR: begin
            addr <= byte_data;
            idx  <= '0;
            wacc <= '0;
            if (addr_wr) phase <= PH_WRITE;
            else if (addr_rd) begin
              phase     <= PH_READ;
              load_pend <= 1'b1;
            end else phase <= PH_DROP;
          end
          PH_WRITE: begin
            wacc <= wr_val;
            idx  <= idx + 1'b1;
            if (last_w) phase <= PH_DROP;
          end
          default: ;
        endcase
      end
      if (sclk_fall && phase == PH_READ) begin
        if (load_pend) begin
          load_pend <= 1'b0;
          reply_d   <= ld_val[RW-1];
          rsh       <= ld_val << 1;
          rbits     <= ld_cnt;
          reply_en  <= 1'b1;
          stat_pend <= (addr == A_STAT);
          clr_mask  <= flags;
        end else if (rbits != '0) begin
          reply_d <= rsh[RW-1];
          rsh     <= rsh << 1;
          rbits   <= rbits - 1'b1;
        end else begin
          reply_en <= 1'b0;
        end
      end
      if (sclk_rise && reply_en && rbits == '0 && stat_pend) begin
        clr_pulse <= 1'b1;
        stat_pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      notone_q <= '0;
      tone1_q  <= '0;
      tone2_q  <= '0;
      gpt_q    <= '0;
    end else if (wr_fire) begin
      unique case (addr)
        A_CTRL:   ctrl_q   <= byte_data;
        A_NOTONE: notone_q <= wr_val;
        A_TONE1:  tone1_q  <= wr_val;
        A_TONE2:  tone2_q  <= wr_val;
        A_GPT:    gpt_q    <= wr_val;
        default:  ;
      endcase
    end
  end

  sbus_irq #(.NSRC(3)) u_irq (
    .clk(clk), .rst(rst),
    .ev({ev_meas, ev_notone, ev_gpt}),
    .clr(clr_pulse), .clr_mask(clr_mask),
    .en_all(ctrl_q[7]),
    .src_dis({ctrl_q[6], ctrl_q[6], ctrl_q[5]}),
    .flags(flags), .irq_drive(irq_drive)
  );
endmodule

// File: rtl/sbus_slave_chk.sv
module sbus_slave_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_act,
  input logic          byte_valid,
  input logic          reply_en,
  input logic          irq_drive,
  input logic          irq_master,
  input logic          flag0,
  input logic          clr_pulse,
  input logic          clr_bit0,
  input logic [DW-1:0] tone1_q
);
  a_r4_reply_quiet: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !reply_en);

  a_r3_no_byte_idle: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !byte_valid);

  a_r8_master_off: assert property (@(posedge clk) disable iff (rst)
    !irq_master |=> !irq_drive);

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag0 && !(clr_pulse && clr_bit0)) |=> flag0);

  a_r1_commit_on_byte: assert property (@(posedge clk) disable iff (rst)
    !$stable(tone1_q) |-> $past(byte_valid));

  a_r11_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!reply_en && !irq_drive && !flag0));
endmodule

bind sbus_slave sbus_slave_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cs_act(cs_act), .byte_valid(byte_valid),
  .reply_en(reply_en), .irq_drive(irq_drive), .irq_master(ctrl_q[7]),
  .flag0(flags[0]), .clr_pulse(clr_pulse), .clr_bit0(clr_mask[0]),
  .tone1_q(tone1_q)
);

// File: tb/sbus_slave_test.sv
module sbus_slave_test;
  localparam int HP = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic sclk_in = 1'b0, csn_in = 1'b1, cmd_in = 1'b0, logic_in = 1'b0;
  logic ev_gpt = 1'b0, ev_notone = 1'b0, ev_meas = 1'b0;
  logic [15:0] rx_freq = '0;
  logic reply_d, reply_en, irq_drive;
  logic [7:0]  ctrl_q;
  logic [15:0] notone_q, tone1_q, tone2_q, gpt_q;

  int tests = 0, fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  sbus_slave uut (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .csn_in(csn_in), .cmd_in(cmd_in),
    .logic_in(logic_in), .ev_gpt(ev_gpt), .ev_notone(ev_notone), .ev_meas(ev_meas),
    .rx_freq(rx_freq), .reply_d(reply_d), .reply_en(reply_en), .irq_drive(irq_drive),
    .ctrl_q(ctrl_q), .notone_q(notone_q), .tone1_q(tone1_q), .tone2_q(tone2_q),
    .gpt_q(gpt_q)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic cs_on();
    @(negedge clk) csn_in = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic cs_off();
    repeat (HP) @(negedge clk);
    csn_in = 1'b1;
    repeat (2*HP) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      cmd_in = b[i];
      repeat (HP) @(negedge clk);
      sclk_in = 1'b1;
      repeat (HP) @(negedge clk);
      sclk_in = 1'b0;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input int nb);
    cs_on();
    send_bits(a, 8);
    for (int i = nb - 1; i >= 0; i--) send_bits(d[8*i +: 8], 8);
    cs_off();
  endtask

  task automatic rd(input logic [7:0] a, input int nb, input logic [15:0] e,
                    input string tag);
    for (int i = nb - 1; i >= 0; i--) begin
      exp_q.push_back(e[8*i +: 8]);
      tag_q.push_back(tag);
    end
    cs_on();
    send_bits(a, 8);
    for (int i = 0; i < nb; i++) send_bits(8'h00, 8);
    cs_off();
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) ev_gpt = 1'b1;
    else if (which == 1) ev_notone = 1'b1;
    else ev_meas = 1'b1;
    @(negedge clk);
    ev_gpt = 1'b0; ev_notone = 1'b0; ev_meas = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // scoreboard monitor: assembles reply bytes at the host sampling edge
  initial begin
    logic [7:0] acc;
    logic [7:0] e;
    string t;
    int n;
    acc = '0; n = 0;
    forever begin
      @(posedge sclk_in);
      if (reply_en) begin
        acc = {acc[6:0], reply_d};
        n++;
        if (n == 8) begin
          n = 0;
          if (exp_q.size() == 0) begin
            check(1'b0, "R4", "reply byte with none expected", acc, 0);
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(acc == e, t, "reply byte", acc, e);
          end
        end
      end else n = 0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "WD", "watchdog expired", 0, 0);
    report();
  end

  initial begin
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R11 reset state
    check(ctrl_q == 0 && tone1_q == 0 && gpt_q == 0, "R11", "regs after reset",
          {ctrl_q, tone1_q}, 0);
    check(!reply_en && !irq_drive, "R11", "outputs after reset",
          {reply_en, irq_drive}, 0);

    wr(8'h30, 32'hA5, 1);
    check(ctrl_q == 8'hA5, "R2", "control write", ctrl_q, 8'hA5);

    wr(8'h34, 32'h1234, 2);
    check(tone1_q == 16'h1234, "R1", "tone1 write", tone1_q, 16'h1234);
    wr(8'h33, 32'h00F1, 2);
    check(notone_q == 16'h00F1, "R1", "notone write", notone_q, 16'h00F1);
    wr(8'h36, 32'h8001, 2);
    check(gpt_q == 16'h8001, "R1", "gpt write", gpt_q, 16'h8001);

    wr(8'h35, 32'hABCD99, 3);
    check(tone2_q == 16'hABCD, "R10", "extra byte dropped", tone2_q, 16'hABCD);

    cs_on(); send_bits(8'h34, 8); send_bits(8'hFF, 4); cs_off();
    check(tone1_q == 16'h1234, "R3", "abort in data byte", tone1_q, 16'h1234);
    cs_on(); send_bits(8'h34, 5); cs_off();
    wr(8'h34, 32'h5678, 2);
    check(tone1_q == 16'h5678, "R3", "idle after abort", tone1_q, 16'h5678);

    wr(8'h3F, 32'h1122, 2);
    check(tone1_q == 16'h5678 && tone2_q == 16'hABCD && ctrl_q == 8'hA5,
          "R9", "unknown address", tone1_q, 16'h5678);
    check(!reply_en, "R4", "idle reply enable", reply_en, 0);

    rx_freq = 16'hC35A;
    rd(8'h32, 2, 16'hC35A, "R6");
    rx_freq = 16'h0F01;
    rd(8'h32, 2, 16'h0F01, "R6");
    check(!reply_en, "R4", "reply released after read", reply_en, 0);

    rd(8'h31, 1, 16'h0000, "R5");
    logic_in = 1'b1;
    pulse(0);
    rd(8'h31, 1, 16'h0009, "R5");
    rd(8'h31, 1, 16'h0008, "R7");
    pulse(1); pulse(2);
    rd(8'h31, 1, 16'h000E, "R5");

    pulse(0);
    fork
      rd(8'h31, 1, 16'h0009, "R7");
      begin
        repeat (HP + 128 + 48) @(negedge clk);
        pulse(2);
      end
    join
    rd(8'h31, 1, 16'h000C, "R7");
    rd(8'h31, 1, 16'h0008, "R7");
    logic_in = 1'b0;

    wr(8'h30, 32'h00, 1);
    pulse(0);
    check(!irq_drive, "R8", "master off", irq_drive, 0);
    wr(8'h30, 32'h80, 1);
    check(irq_drive, "R8", "gpt enabled", irq_drive, 1);
    wr(8'h30, 32'hA0, 1);
    check(!irq_drive, "R8", "gpt masked by bit5", irq_drive, 0);
    pulse(1);
    check(irq_drive, "R8", "notone unmasked", irq_drive, 1);
    wr(8'h30, 32'hE0, 1);
    check(!irq_drive, "R8", "both masked", irq_drive, 0);
    wr(8'h30, 32'hC0, 1);
    check(irq_drive, "R8", "gpt unmasked under bit6", irq_drive, 1);
    rd(8'h31, 1, 16'h0003, "R7");
    repeat (4) @(negedge clk);
    check(!irq_drive, "R8", "released after status read", irq_drive, 0);

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R4", "expected reply bytes missing", exp_q.size(), 0);
    report();
  end
endmodule